// File: doc/BRIEF.md
# Oversampled Serial Receiver with Request-to-Send Output

This block recovers 8-bit characters from an asynchronous serial input. The input line is first brought into the clock domain through a two-flop synchronizer. A falling edge starts a character. The line is oversampled sixteen times per bit, and the block samples near the centre of each bit. Each character carries one start bit, eight data bits sent least significant bit first, no parity, and one stop bit. A finished character is placed in a single holding register. A consumer reads it through a valid/ready handshake, and each handshake stands for one polled read of the received data.

The block drives a request-to-send output that tells the far transmitter whether one more character can be accepted. The output is withdrawn as soon as a start bit is confirmed, because the character that follows would fill the holding register. It stays withdrawn while the register is full, and it comes back on the cycle after the register is read, provided no character is arriving. Request-to-send generation can be turned off. When it is off, the output sits permanently at its "may send" level. A polarity input chooses between active-low signalling, which is the default, and active-high signalling.

If a character completes while the register still holds an unread one, the new character is dropped and a sticky overrun flag is raised. A low stop bit marks the character with a framing error, but the character is still stored.

Top module: `uart_rx_rts`

## Requirements
- R1: After reset, rd_valid and rx_overrun are 0. With rts_en=1 and rts_pol=0, rts_out is 0, which is the "may send" level.
- R2: A character is a low start bit, then 8 data bits least significant bit first, then a high stop bit. Each bit lasts OSR*PRESCALE clocks. Once the stop bit is sampled, rd_valid goes to 1 and rd_data holds the 8 data bits.
- R3: A low pulse on rxd that is shorter than half a bit period is rejected at the start-bit midpoint check. No character is stored.
- R4: If the stop bit is sampled low, rd_frame_err is 1 for that character and the character is still stored.
- R5: While rd_valid=1 and rd_ready=0, rd_valid stays 1 and rd_data and rd_frame_err hold steady. A cycle with rd_valid=1 and rd_ready=1 empties the register, so rd_valid is 0 on the next cycle.
- R6: A character that completes while the register is full is discarded and the earlier data is kept. rx_overrun becomes 1 and stays 1 until the next read handshake.
- R7: With rts_en=1, rts_out is at the "hold off" level whenever the register is full.
- R8: With rts_en=1, rts_out goes to "hold off" from the cycle after the start bit is confirmed at its midpoint until the character is stored. This happens even when the register is empty.
- R9: With rts_en=1, rts_out returns to "may send" on the cycle after a read handshake if no character is in progress.
- R10: With rts_pol=0, "may send" is rts_out=0 and "hold off" is rts_out=1. With rts_pol=1, both levels are inverted.
- R11: With rts_en=0, rts_out stays at the "may send" level at all times, including while a character is arriving and while the register is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial input, high when idle |
| rts_en | input | 1 | Enables request-to-send generation |
| rts_pol | input | 1 | 0: active-low request-to-send, 1: active-high |
| rd_valid | output | 1 | Holding register contains an unread character |
| rd_ready | input | 1 | Consumer accepts the character in this cycle |
| rd_data | output | 8 | Received character |
| rd_frame_err | output | 1 | Stop bit of the held character was sampled low |
| rx_overrun | output | 1 | A character was dropped because the register was full |
| rts_out | output | 1 | Request-to-send output to the far transmitter |

## Verification
The bench checks request-to-send in the middle of a character that is arriving into an empty register. A design that waits for the register to fill before withdrawing the output fails that check. A short low glitch on the line is sent to catch a receiver that trusts the falling edge without the midpoint check and so stores a spurious character. A second character is sent into an unread register to catch a design that overwrites the old data or never raises overrun. The bench reads the register and checks the output one cycle later, which catches a lagging re-assertion. Random characters with random polarity and occasional low stop bits expose bit-order, framing and polarity mistakes.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W       = 8;
    localparam int OSR_DEF      = 16;
    localparam int PRESCALE_DEF = 2;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ferr;
    } rx_char_t;

    // Pin level for a given logical request-to-send state
    function automatic logic rts_level(input logic may_send, input logic pol);
        return pol ? may_send : ~may_send;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync (
    input  logic clk,
    input  logic rst,
    input  logic rxd,
    output logic line,
    output logic fall
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= 3'b111;
        else     sh <= {sh[1:0], rxd};
    end

    assign line = sh[1];
    assign fall = sh[2] & ~sh[1];
endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
    parameter int PRESCALE = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (PRESCALE <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_div
            localparam int W = $clog2(PRESCALE);
            logic [W-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst)                         cnt <= '0;
                else if (cnt == W'(PRESCALE-1))  cnt <= '0;
                else                             cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == W'(PRESCALE-1));
        end
    endgenerate
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     line,
    input  logic     fall,
    output logic     busy,
    output logic     done,
    output rx_char_t ch
);
    localparam int CW   = $clog2(OSR);
    localparam int HALF = OSR / 2;
    localparam int IW   = $clog2(DATA_W);

    rx_state_e         st;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     idx;
    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            done  <= 1'b0;
            ch    <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (fall) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (cnt == CW'(HALF-1)) begin
                            cnt <= '0;
                            idx <= '0;
                            st  <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (cnt == CW'(OSR-1)) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[DATA_W-1:1]};
                            if (idx == IW'(DATA_W-1)) st  <= RX_STOP;
                            else                      idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (cnt == CW'(OSR-1)) begin
                            cnt     <= '0;
                            done    <= 1'b1;
                            ch.data <= shreg;
                            ch.ferr <= ~line;
                            st      <= RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    // A confirmed character is in flight until the holding stage takes it
    assign busy = (st == RX_DATA) || (st == RX_STOP) || done;
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_char_t          ch,
    input  logic              busy,
    input  logic              rd_ready,
    input  logic              rts_en,
    input  logic              rts_pol,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_frame_err,
    output logic              rx_overrun,
    output logic              rts_out
);
    logic     full;
    rx_char_t held;
    logic     rd_fire;

    assign rd_fire = full & rd_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            full       <= 1'b0;
            held       <= '0;
            rx_overrun <= 1'b0;
        end else begin
            if (done && (!full || rd_fire)) begin
                full <= 1'b1;
                held <= ch;
            end else if (rd_fire) begin
                full <= 1'b0;
            end
            if (done && full && !rd_fire) rx_overrun <= 1'b1;
            else if (rd_fire)             rx_overrun <= 1'b0;
        end
    end

    assign rd_valid     = full;
    assign rd_data      = held.data;
    assign rd_frame_err = held.ferr;

    logic may_send;
    assign may_send = rts_en ? (~full & ~busy) : 1'b1;
    assign rts_out  = rts_level(may_send, rts_pol);
endmodule

// File: rtl/uart_rx_rts.sv
module uart_rx_rts
    import uart_rx_pkg::*;
#(
    parameter int OSR      = OSR_DEF,
    parameter int PRESCALE = PRESCALE_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd,
    input  logic              rts_en,
    input  logic              rts_pol,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_frame_err,
    output logic              rx_overrun,
    output logic              rts_out
);
    logic     line, fall, tick, busy, done;
    rx_char_t ch;

    uart_rx_sync u_sync (
        .clk (clk), .rst (rst), .rxd (rxd), .line (line), .fall (fall)
    );

    uart_rx_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk (clk), .rst (rst), .tick (tick)
    );

    uart_rx_frame #(.OSR(OSR)) u_frame (
        .clk (clk), .rst (rst), .tick (tick), .line (line), .fall (fall),
        .busy (busy), .done (done), .ch (ch)
    );

    uart_rx_hold u_hold (
        .clk (clk), .rst (rst), .done (done), .ch (ch), .busy (busy),
        .rd_ready (rd_ready), .rts_en (rts_en), .rts_pol (rts_pol),
        .rd_valid (rd_valid), .rd_data (rd_data), .rd_frame_err (rd_frame_err),
        .rx_overrun (rx_overrun), .rts_out (rts_out)
    );
endmodule

// File: rtl/uart_rx_rts_chk.sv
module uart_rx_rts_chk (
    input logic       clk,
    input logic       rst,
    input logic       rts_en,
    input logic       rts_pol,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data,
    input logic       rd_frame_err,
    input logic       rx_overrun,
    input logic       rts_out,
    input logic       busy,
    input logic       done
);
    AST_HOLD_WHILE_FULL: assert property (@(posedge clk) disable iff (rst)
        rts_en && rd_valid |-> rts_out == ~rts_pol); // R7

    AST_HOLD_WHILE_ARRIVING: assert property (@(posedge clk) disable iff (rst)
        rts_en && busy |-> rts_out == ~rts_pol); // R8

    AST_MAY_SEND_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        rts_en && !rd_valid && !busy |-> rts_out == rts_pol); // R9

    AST_DISABLED_MAY_SEND: assert property (@(posedge clk) disable iff (rst)
        !rts_en |-> rts_out == rts_pol); // R11

    AST_VALID_HELD: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_frame_err)); // R5

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        rd_valid && rd_ready && !done |=> !rd_valid); // R5

    AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> rd_valid && $stable(rd_data)); // R6
endmodule

bind uart_rx_rts uart_rx_rts_chk u_chk (
    .clk (clk), .rst (rst), .rts_en (rts_en), .rts_pol (rts_pol),
    .rd_valid (rd_valid), .rd_ready (rd_ready), .rd_data (rd_data),
    .rd_frame_err (rd_frame_err), .rx_overrun (rx_overrun), .rts_out (rts_out),
    .busy (busy), .done (done)
);

// File: tb/uart_rx_rts_tb.sv
module uart_rx_rts_tb_top;
    localparam int OSR = 16;
    localparam int PRE = 2;
    localparam int BIT = OSR * PRE;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       rts_en = 1'b1;
    logic       rts_pol = 1'b0;
    logic       rd_ready = 1'b0;
    logic       rd_valid, rd_frame_err, rx_overrun, rts_out;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    uart_rx_rts #(.OSR(OSR), .PRESCALE(PRE)) dut_i (
        .clk (clk), .rst (rst), .rxd (rxd), .rts_en (rts_en), .rts_pol (rts_pol),
        .rd_valid (rd_valid), .rd_ready (rd_ready), .rd_data (rd_data),
        .rd_frame_err (rd_frame_err), .rx_overrun (rx_overrun), .rts_out (rts_out)
    );

    function automatic logic lvl(input bit may_send, input bit pol);
        return pol ? may_send : ~may_send;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drives one character; checks request-to-send in the middle of data bit 3
    task automatic send_char(input logic [7:0] d, input bit stop_ok);
        rxd = 1'b0;
        cyc(BIT);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            cyc(BIT / 2);
            if (i == 3) begin
                if (rts_en) chk("R8 rts held off mid-character", rts_out, lvl(0, rts_pol));
                else        chk("R11 rts may-send while disabled", rts_out, lvl(1, rts_pol));
            end
            cyc(BIT - BIT / 2);
        end
        rxd = stop_ok;
        cyc(BIT);
        rxd = 1'b1;
        cyc(4);
    endtask

    task automatic do_read();
        rd_ready = 1'b1;
        cyc(1);
        rd_ready = 1'b0;
        chk("R5 register empty after read", rd_valid, 0);
        if (rts_en) chk("R9 rts back the cycle after read", rts_out, lvl(1, rts_pol));
    endtask

    initial begin
        void'($urandom(32'd4242));
        cyc(5);
        rst = 1'b0;
        cyc(2);
        chk("R1 reset valid", rd_valid, 0);
        chk("R1 reset overrun", rx_overrun, 0);
        chk("R1 reset rts", rts_out, 0);

        // Directed: normal character, hold without ready
        send_char(8'hA5, 1);
        chk("R2 valid", rd_valid, 1);
        chk("R2 data", rd_data, 8'hA5);
        chk("R4 no frame error", rd_frame_err, 0);
        chk("R7 rts held off while full", rts_out, 1);
        cyc(50);
        chk("R5 valid held", rd_valid, 1);
        chk("R5 data held", rd_data, 8'hA5);
        do_read();

        // Framing error
        send_char(8'h3C, 0);
        chk("R4 frame error flagged", rd_frame_err, 1);
        chk("R4 data still stored", rd_data, 8'h3C);
        do_read();

        // Short glitch
        rxd = 1'b0;
        cyc(4);
        rxd = 1'b1;
        cyc(3 * BIT);
        chk("R3 glitch rejected", rd_valid, 0);
        chk("R3 rts unaffected by glitch", rts_out, 0);

        // Overrun
        send_char(8'h11, 1);
        send_char(8'h22, 1);
        chk("R6 old data kept", rd_data, 8'h11);
        chk("R6 overrun set", rx_overrun, 1);
        do_read();
        chk("R6 overrun cleared by read", rx_overrun, 0);

        // Inverted polarity
        rts_pol = 1'b1;
        cyc(2);
        chk("R10 active-high may-send", rts_out, 1);
        send_char(8'h81, 1);
        chk("R10 active-high hold off", rts_out, 0);
        chk("R2 data msb/lsb", rd_data, 8'h81);
        do_read();

        // Disabled generation
        rts_en = 1'b0;
        rts_pol = 1'b0;
        send_char(8'h5A, 1);
        chk("R11 may-send while full", rts_out, 0);
        chk("R2 data while disabled", rd_data, 8'h5A);
        do_read();
        rts_en = 1'b1;
        cyc(2);

        // Random characters
        for (int k = 0; k < 40; k++) begin
            logic [7:0] d = 8'($urandom);
            bit ok = ($urandom % 8) != 0;
            rts_pol = 1'($urandom);
            cyc(2);
            chk("R10 idle level", rts_out, lvl(1, rts_pol));
            send_char(d, ok);
            chk("R2 random valid", rd_valid, 1);
            chk("R2 random data", rd_data, d);
            chk("R4 random frame flag", rd_frame_err, !ok);
            chk("R7 random hold off", rts_out, lvl(0, rts_pol));
            cyc($urandom % 20);
            chk("R5 random data held", rd_data, d);
            do_read();
            cyc($urandom % 40);
        end

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end
endmodule